// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block is a small register pipeline whose state flops double as a scan chain, together with a state machine that runs a complete scan test over them. The wrapped logic adds the functional input word to the register contents. Every flop is a muxed-D scan cell. With the scan enable low, each cell takes its functional input. With the scan enable high, each cell takes the output of its neighbour, and the whole register becomes one shift path from `scan_in` to `scan_out`.

When the sequencer is idle, the registers act as a plain accumulator. A start request moves the sequencer from `ST_IDLE` to `ST_LOAD`, where it shifts the stimulus in for `N` cycles (transition LOAD→CAPTURE on the last count). `ST_CAPTURE` then applies one functional clock. `ST_UNLOAD` shifts the response out for `N` cycles and, at the same time, shifts in whatever bits the tester supplies. On the last unload cycle there are two exits: UNLOAD→CAPTURE if start is high, which treats the bits just loaded as the next stimulus, or UNLOAD→IDLE otherwise. Back-to-back tests therefore cost `N+1` cycles each.

Top module: `scan_test_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `done`, `scan_en`, `capture` and `resp_valid` are low and `func_out` is zero.
- R2: While `busy` is low, every clock sets `func_out` to the previous `func_out` plus `func_in`, modulo 2^N, and `scan_en`, `capture` and `resp_valid` stay low.
- R3: A start sampled while idle makes `busy` high on the next cycle. Each clock with `scan_en` high moves `scan_in` into bit N-1 and shifts every other bit down by one. `scan_out` always shows bit 0.
- R4: After the N load shifts, bit i of `func_out` holds the i-th bit shifted in, counting from 0. The first bit shifted in therefore sits in bit 0, the cell nearest `scan_out`.
- R5: Exactly one capture cycle follows the load. In that cycle `capture` is high and `scan_en` is low, and the clock loads the functional sum of the loaded stimulus and `func_in`.
- R6: After capture, `resp_valid` is high for N cycles, and `scan_out` presents the captured response LSB first, one bit per cycle.
- R7: `done` is a one-cycle pulse in the cycle after the last unload shift. A single test keeps `busy` high for exactly 2N+1 cycles.
- R8: Start high during the last unload cycle sends the sequencer straight to capture, using the N bits shifted in during that unload as the next stimulus. K chained tests keep `busy` high for N+K(N+1) cycles.
- R9: Start is ignored while `busy` is high, except in the last unload cycle.
- R10: After a test ends, `func_out` holds the bits shifted in during the final unload, and accumulation per R2 resumes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_in | input | N | Functional operand added to the registers |
| start | input | 1 | Test request; also chains the next test on the last unload cycle |
| scan_in | input | 1 | Serial stimulus bit |
| func_out | output | N | Register contents |
| scan_out | output | 1 | Serial response bit (register bit 0) |
| scan_en | output | 1 | Shift select applied to every cell |
| capture | output | 1 | High in the single capture cycle |
| resp_valid | output | 1 | `scan_out` carries a response bit |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse after the last response bit |

## Verification
The properties assume that `func_in` is stable during the capture cycle. They also assume that `scan_in` is driven to a known value on every cycle where `scan_en` is high, and that reset is released away from a clock edge. The bench changes every input only on falling edges. It holds `func_in` constant for the whole of each test and drives a defined stimulus or fill bit on every shift cycle. It raises start only while idle, or in the hold pattern that exercises R9, or in the last unload cycle when it chains tests.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_UNLOAD  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic se,
    input  logic d,
    input  logic si,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= se ? si : d;
    end
endmodule

// File: rtl/scan_comb.sv
module scan_comb #(
    parameter int N = 8
) (
    input  logic [N-1:0] state_q,
    input  logic [N-1:0] operand,
    output logic [N-1:0] next_d
);
    // Wrapped logic under test: modular sum of the register word and operand
    always_comb next_d = state_q + operand;
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic scan_en,
    output logic capture,
    output logic resp_valid,
    output logic busy,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    seq_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic last;

    assign last = (cnt == CW'(N - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_LOAD;
            ST_LOAD:    if (last)  state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = ST_UNLOAD;
            ST_UNLOAD:  if (last)  state_nx = start ? ST_CAPTURE : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_LOAD || state == ST_UNLOAD)
                cnt <= last ? '0 : cnt + 1'b1;
            else
                cnt <= '0;
            done <= (state == ST_UNLOAD) && last;
        end
    end

    always_comb begin
        scan_en    = 1'b0;
        capture    = 1'b0;
        resp_valid = 1'b0;
        busy       = 1'b1;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_LOAD:    scan_en = 1'b1;
            ST_CAPTURE: capture = 1'b1;
            ST_UNLOAD: begin
                scan_en    = 1'b1;
                resp_valid = 1'b1;
            end
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] func_in,
    input  logic         start,
    input  logic         scan_in,
    output logic [N-1:0] func_out,
    output logic         scan_out,
    output logic         scan_en,
    output logic         capture,
    output logic         resp_valid,
    output logic         busy,
    output logic         done
);
    logic [N-1:0] chain_q;
    logic [N-1:0] comb_d;

    scan_comb #(.N(N)) u_comb (
        .state_q (chain_q),
        .operand (func_in),
        .next_d  (comb_d)
    );

    scan_seq_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .scan_en    (scan_en),
        .capture    (capture),
        .resp_valid (resp_valid),
        .busy       (busy),
        .done       (done)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic si_w;
        if (i == N - 1) begin : g_head
            assign si_w = scan_in;
        end else begin : g_link
            assign si_w = chain_q[i+1];
        end
        scan_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .se    (scan_en),
            .d     (comb_d[i]),
            .si    (si_w),
            .q     (chain_q[i])
        );
    end

    assign func_out = chain_q;
    assign scan_out = chain_q[0];
endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] func_in,
    input logic         start,
    input logic         scan_in,
    input logic [N-1:0] func_out,
    input logic         scan_out,
    input logic         scan_en,
    input logic         capture,
    input logic         resp_valid,
    input logic         busy,
    input logic         done
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scan_en && !capture && !resp_valid));

    p_accumulate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!busy)) |-> func_out == N'($past(func_out) + $past(func_in)));

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scan_en) |-> func_out == {$past(scan_in), $past(func_out[N-1:1])});

    p_out_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == func_out[0]);

    p_capture_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture && scan_en));

    p_capture_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

    p_unload_after_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(capture));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(resp_valid));
endmodule

bind scan_test_seq scan_test_seq_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .func_in    (func_in),
    .start      (start),
    .scan_in    (scan_in),
    .func_out   (func_out),
    .scan_out   (scan_out),
    .scan_en    (scan_en),
    .capture    (capture),
    .resp_valid (resp_valid),
    .busy       (busy),
    .done       (done)
);

// File: tb/scan_test_seq_bench.sv
module scan_test_seq_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] func_in = '0;
    logic         start = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_out;
    logic         scan_out, scan_en, capture, resp_valid, busy, done;

    int checks = 0;
    int fails  = 0;
    int run_len = 0;

    logic [N-1:0] sb_q[$];
    logic [N-1:0] stim_v[5];
    logic [N-1:0] acc = '0;
    int           nbits = 0;

    always #5 clk = ~clk;

    scan_test_seq #(.N(N)) u_scan_test_seq (
        .clk(clk), .rst_n(rst_n), .func_in(func_in), .start(start),
        .scan_in(scan_in), .func_out(func_out), .scan_out(scan_out),
        .scan_en(scan_en), .capture(capture), .resp_valid(resp_valid),
        .busy(busy), .done(done)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Busy-run length measured independently of the driver
    always @(posedge clk) begin
        if (busy) run_len <= run_len + 1;
        else      run_len <= 0;
    end

    // Monitor: gathers response bits LSB first and compares with the scoreboard (R6)
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            acc[nbits] = scan_out;
            nbits++;
            if (nbits == N) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 unexpected response", int'(acc), 0);
                end else begin
                    logic [N-1:0] e;
                    e = sb_q.pop_front();
                    check(acc == e, "R6 response word", int'(acc), int'(e));
                end
                nbits = 0;
            end
        end
    end

    // Driver: k tests chained, stim_v[k] is the fill shifted in by the last unload
    task automatic run_seq(input int k, input logic hold);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        start = hold;
        for (int j = 0; j < N; j++) begin
            scan_in = stim_v[0][j];
            @(posedge clk); @(negedge clk);
        end
        check(func_out == stim_v[0], "R4 load ordering", int'(func_out), int'(stim_v[0]));
        check(capture && !scan_en, "R5 capture cycle", int'({capture, scan_en}), 2);
        for (int t = 0; t < k; t++) begin
            sb_q.push_back(N'(stim_v[t] + func_in));
            @(posedge clk); @(negedge clk);
            for (int j = 0; j < N; j++) begin
                scan_in = stim_v[t+1][j];
                start = (j == N - 1) ? (t < k - 1) : hold;
                @(posedge clk); @(negedge clk);
            end
            check(done == 1'b1, "R7 done pulse", int'(done), 1);
            if (t < k - 1) begin
                check(busy && capture, "R8 chained capture", int'({busy, capture}), 3);
                check(func_out == stim_v[t+1], "R8 chained stimulus", int'(func_out), int'(stim_v[t+1]));
            end
        end
        start = 1'b0;
        check(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
        check(run_len == N + k * (N + 1), "R7 R8 busy length", run_len, N + k * (N + 1));
        check(func_out == stim_v[k], "R10 fill left in chain", int'(func_out), int'(stim_v[k]));
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", int'(done), 0);
        check(func_out == N'(stim_v[k] + func_in), "R10 accumulate resumes",
              int'(func_out), int'(N'(stim_v[k] + func_in)));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !scan_en && !capture && !resp_valid && func_out == '0,
              "R1 reset state", int'(func_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && func_out == '0, "R1 after release", int'(func_out), 0);

        // R2: idle accumulation with wraparound
        func_in = 8'hC0;
        @(negedge clk);
        check(func_out == 8'hC0, "R2 accumulate 1", int'(func_out), 'hC0);
        @(negedge clk);
        check(func_out == 8'h80, "R2 accumulate wrap", int'(func_out), 'h80);
        check(!scan_en && !resp_valid, "R2 idle controls", int'({scan_en, resp_valid}), 0);

        // Single test, zero operand: response equals stimulus
        func_in = 8'h00;
        stim_v[0] = 8'hA5; stim_v[1] = 8'h3C;
        run_seq(1, 1'b0);

        // Three chained tests (R8)
        func_in = 8'h11;
        stim_v[0] = 8'h01; stim_v[1] = 8'hFE; stim_v[2] = 8'h80; stim_v[3] = 8'h5A;
        run_seq(3, 1'b0);

        // R9: start held high throughout a single test, dropped at the last unload cycle
        func_in = 8'h7F;
        stim_v[0] = 8'h81; stim_v[1] = 8'hC3;
        run_seq(1, 1'b1);

        repeat (2) @(negedge clk);
        check(sb_q.size() == 0 && nbits == 0, "R6 all responses seen", sb_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule